// File: doc/BRIEF.md
# Indirect Configuration Transaction Controller

This block gives software a mailbox-style path into a small bank of 32-bit oscillator-setting words that sit behind it. Four registers sit on a simple word-addressed register bus. Software first places a value in the outgoing data register. It then writes the control register with three things: a device index, a function code and a direction bit, with the start bit set. The transaction completes on the next clock. The status register then shows completion and, when the request was bad, an error flag. A read transaction leaves the selected word in the return data register.

The depth of the oscillator bank and the reset value of each word are parameters. The whole bank is also driven out on a flat output bus, so the clock generators fed by these words can use them directly. A control write always clears the status first. The start bit and the reserved bits of the control register are dropped and are never stored.

Top module: `cfg_xact_ctrl`

## Requirements
- R1: After reset, the register reads are: control 0x00100000 (function 1, device 0), status 0, return data 0 and outgoing data 0. Each oscillator word i holds OSC_INIT[32*i+31:32*i].
- R2: The outgoing data register at offset 0xA4 reads back the last value written to it.
- R3: A write to the control register at offset 0xA8 stores only these bits: device index [11:0], function [25:20] and the write-direction bit 30. Bits [19:12], [29:26] and the start bit 31 always read back as zero.
- R4: Every control write clears the status register at offset 0xAC. In the cycle after the write, status reads zero, whether or not start was set.
- R5: A control write with start (bit 31) set completes one cycle after the write. Status bit 0 (done) then reads 1, provided no further control write arrives in that completion cycle. A control write in that cycle replaces the pending transaction.
- R6: A valid transaction with bit 30 = 1 copies the outgoing data register into oscillator word [device] on completion. All other words stay unchanged.
- R7: A valid transaction with bit 30 = 0 loads oscillator word [device] into the return data register at offset 0xA0 on completion.
- R8: A function code other than 1 sets status bit 1 (error) together with done. The oscillator bank and the return data register are left unchanged.
- R9: A device index equal to or greater than DEPTH sets the error bit together with done. The oscillator bank and the return data register are left unchanged.
- R10: Writes to the return data register and to the status register are ignored.
- R11: A read from any offset other than 0xA0, 0xA4, 0xA8 or 0xAC returns zero. A write to such an offset changes no register.
- R12: A control write with start clear runs no transaction. Status stays zero, and the bank and the return data are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | ADDR_W | Byte offset of the register access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| oscOut | output | 32*DEPTH | Current oscillator words, word i at bits [32*i+31:32*i] |

## Verification
Some properties are checked on every cycle: the control register never reads back with start or reserved bits set, and the error flag never appears without done. Every control write leaves status cleared. A start write left alone is followed by done. The oscillator outputs and the return data move only in a completion cycle. Some behaviour only the bench scenarios can show. This covers the values themselves: that the right word is written or returned, and that out-of-range devices or wrong function codes leave the bank unchanged. It also covers the reset contents and the read-only and unmapped offsets.

// File: rtl/cfg_xact_pkg.sv
package cfg_xact_pkg;

  localparam logic [7:0] OFS_RTN  = 8'hA0;
  localparam logic [7:0] OFS_OUT  = 8'hA4;
  localparam logic [7:0] OFS_CTRL = 8'hA8;
  localparam logic [7:0] OFS_STAT = 8'hAC;

  localparam int DEV_LSB  = 0;
  localparam int DEV_W    = 12;
  localparam int FUNC_LSB = 20;
  localparam int FUNC_W   = 6;
  localparam int WR_BIT   = 30;
  localparam int GO_BIT   = 31;

  localparam logic [31:0] CTRL_KEEP  = 32'h43F0_0FFF;
  localparam logic [31:0] CTRL_RESET = 32'h0010_0000;
  localparam logic [FUNC_W-1:0] FUNC_OSC = 6'd1;

  typedef struct packed {
    logic ctrlWe;
    logic outWe;
    logic xactDone;
    logic xactErr;
    logic arrayWe;
    logic rtnWe;
  } strobe_t;

endpackage

// File: rtl/cfg_xact_seq.sv
module cfg_xact_seq
  import cfg_xact_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              goBit,
  input  logic [DEV_W-1:0]  ctrlDev,
  input  logic [FUNC_W-1:0] ctrlFunc,
  input  logic              ctrlWr,
  output strobe_t           strb,
  output logic              pendQ
);

  localparam logic [DEV_W-1:0] DEV_LIMIT = DEV_W'(DEPTH);

  logic ctlHit;
  logic outHit;
  logic finish;
  logic reqValid;

  assign ctlHit   = busWrEn && (busAddr == ADDR_W'(OFS_CTRL));
  assign outHit   = busWrEn && (busAddr == ADDR_W'(OFS_OUT));
  assign finish   = pendQ && !ctlHit;
  assign reqValid = (ctrlFunc == FUNC_OSC) && (ctrlDev < DEV_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= ctlHit && goBit;
  end

  always_comb begin
    strb          = '0;
    strb.ctrlWe   = ctlHit;
    strb.outWe    = outHit;
    strb.xactDone = finish;
    strb.xactErr  = finish && !reqValid;
    strb.arrayWe  = finish && reqValid && ctrlWr;
    strb.rtnWe    = finish && reqValid && !ctrlWr;
  end

endmodule

// File: rtl/cfg_xact_dp.sv
module cfg_xact_dp
  import cfg_xact_pkg::*;
#(
  parameter int                  DEPTH    = 4,
  parameter int                  ADDR_W   = 12,
  parameter logic [DEPTH*32-1:0] OSC_INIT = {DEPTH{32'h0000_0000}}
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic [DEV_W-1:0]  ctrlDev,
  output logic [FUNC_W-1:0] ctrlFunc,
  output logic              ctrlWr,
  output logic [1:0]        statBits,
  output logic [31:0]       rtnVal,
  output logic [DEPTH*32-1:0] oscOut
);

  logic [31:0] outQ;
  logic [31:0] rtnQ;
  logic [31:0] ctrlQ;
  logic [1:0]  statQ;
  logic [31:0] oscQ [DEPTH];
  logic [31:0] selWord;

  assign ctrlDev  = ctrlQ[DEV_LSB +: DEV_W];
  assign ctrlFunc = ctrlQ[FUNC_LSB +: FUNC_W];
  assign ctrlWr   = ctrlQ[WR_BIT];
  assign statBits = statQ;
  assign rtnVal   = rtnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ  <= '0;
      rtnQ  <= '0;
      ctrlQ <= CTRL_RESET;
      statQ <= '0;
    end else begin
      if (strb.outWe)  outQ  <= busWrData;
      if (strb.ctrlWe) ctrlQ <= busWrData & CTRL_KEEP;
      if (strb.rtnWe)  rtnQ  <= selWord;
      if (strb.ctrlWe)        statQ <= 2'b00;
      else if (strb.xactDone) statQ <= {strb.xactErr, 1'b1};
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_osc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) oscQ[i] <= OSC_INIT[32*i +: 32];
      else if (strb.arrayWe && (ctrlDev == DEV_W'(i))) oscQ[i] <= outQ;
    end
    assign oscOut[32*i +: 32] = oscQ[i];
  end

  always_comb begin
    selWord = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ctrlDev == DEV_W'(i)) selWord = oscQ[i];
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_W'(OFS_RTN):  busRdData = rtnQ;
      ADDR_W'(OFS_OUT):  busRdData = outQ;
      ADDR_W'(OFS_CTRL): busRdData = ctrlQ;
      ADDR_W'(OFS_STAT): busRdData = {30'b0, statQ};
      default:           busRdData = '0;
    endcase
  end

endmodule

// File: rtl/cfg_xact_ctrl.sv
module cfg_xact_ctrl
  import cfg_xact_pkg::*;
#(
  parameter int                  DEPTH    = 4,
  parameter int                  ADDR_W   = 12,
  parameter logic [DEPTH*32-1:0] OSC_INIT = {DEPTH{32'h0000_0000}}
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  output logic [DEPTH*32-1:0] oscOut
);

  strobe_t           strb;
  logic              pendQ;
  logic [DEV_W-1:0]  ctrlDev;
  logic [FUNC_W-1:0] ctrlFunc;
  logic              ctrlWr;
  logic [1:0]        statBits;
  logic [31:0]       rtnVal;

  cfg_xact_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .goBit(busWrData[GO_BIT]), .ctrlDev(ctrlDev), .ctrlFunc(ctrlFunc),
    .ctrlWr(ctrlWr), .strb(strb), .pendQ(pendQ)
  );

  cfg_xact_dp #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .OSC_INIT(OSC_INIT)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .ctrlDev(ctrlDev),
    .ctrlFunc(ctrlFunc), .ctrlWr(ctrlWr), .statBits(statBits),
    .rtnVal(rtnVal), .oscOut(oscOut)
  );

endmodule

// File: rtl/cfg_xact_ctrl_chk.sv
module cfg_xact_ctrl_chk
  import cfg_xact_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWrEn,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [31:0]         busWrData,
  input logic [31:0]         busRdData,
  input logic [DEPTH*32-1:0] oscOut,
  input logic                pendQ,
  input logic [1:0]          statBits,
  input logic [31:0]         rtnVal
);

  logic ctlHit;
  assign ctlHit = busWrEn && (busAddr == ADDR_W'(OFS_CTRL));

  p_ctrl_clean_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(OFS_CTRL)) |-> ((busRdData & ~CTRL_KEEP) == 32'h0));

  p_stat_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctlHit |=> (statBits == 2'b00));

  p_done_after_go_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctlHit && busWrData[GO_BIT]) ##1 !ctlHit |=> statBits[0]);

  p_err_has_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    statBits[1] |-> statBits[0]);

  p_osc_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !pendQ |=> $stable(oscOut));

  p_rtn_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !pendQ |=> $stable(rtnVal));

endmodule

bind cfg_xact_ctrl cfg_xact_ctrl_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .busRdData(busRdData), .oscOut(oscOut),
  .pendQ(pendQ), .statBits(statBits), .rtnVal(rtnVal)
);

// File: tb/cfg_xact_ctrl_tb_top.sv
module cfg_xact_ctrl_tb_top;

  localparam int DEPTH  = 4;
  localparam int ADDR_W = 12;
  localparam logic [DEPTH*32-1:0] INIT =
    {32'h0D0D_4444, 32'h0C0C_3333, 32'h0B0B_2222, 32'h0A0A_1111};

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                busWrEn = 1'b0;
  logic [ADDR_W-1:0]   busAddr = '0;
  logic [31:0]         busWrData = '0;
  logic [31:0]         busRdData;
  logic [DEPTH*32-1:0] oscOut;

  int total = 0;
  int bad = 0;

  logic [31:0] mOsc [DEPTH];
  logic [31:0] mOut, mRtn, mCtrl, mStat;

  always #4 clk = ~clk;

  cfg_xact_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .OSC_INIT(INIT)) dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .oscOut(oscOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  function automatic logic [31:0] keepCtrl(input logic [31:0] d);
    return d & 32'h43F0_0FFF;
  endfunction

  function automatic logic isValid(input logic [31:0] c);
    return (c[25:20] == 6'd1) && (c[11:0] < 12'(DEPTH));
  endfunction

  task automatic checkOsc(input string req);
    for (int i = 0; i < DEPTH; i++) check(req, oscOut[32*i +: 32], mOsc[i]);
  endtask

  task automatic checkRegs(input string req);
    logic [31:0] v;
    rd(12'hA0, v); check(req, v, mRtn);
    rd(12'hA4, v); check(req, v, mOut);
    rd(12'hA8, v); check(req, v, mCtrl);
    rd(12'hAC, v); check(req, v, mStat);
  endtask

  task automatic ctrlWrite(input string req, input logic [31:0] d);
    logic [31:0] v;
    wr(12'hA8, d);
    mCtrl = keepCtrl(d);
    mStat = 0;
    rd(12'hAC, v); check("R4", v, 32'h0);
    @(negedge clk);
    if (d[31]) begin
      mStat = isValid(mCtrl) ? 32'h1 : 32'h3;
      if (isValid(mCtrl)) begin
        if (mCtrl[30]) mOsc[mCtrl[11:0]] = mOut;
        else           mRtn = mOsc[mCtrl[11:0]];
      end
    end
    rd(12'hAC, v); check(req, v, mStat);
    rd(12'hA0, v); check(req, v, mRtn);
    checkOsc(req);
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < DEPTH; i++) mOsc[i] = INIT[32*i +: 32];
    mOut = 0; mRtn = 0; mCtrl = 32'h0010_0000; mStat = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    checkRegs("R1");
    checkOsc("R1");

    wr(12'hA4, 32'hCAFE_F00D); mOut = 32'hCAFE_F00D;
    rd(12'hA4, v); check("R2", v, mOut);

    ctrlWrite("R3", 32'h3C0F_F000);
    rd(12'hA8, v); check("R3", v, 32'h0);
    ctrlWrite("R12", 32'h7FFF_FFFF);
    rd(12'hA8, v); check("R3", v, 32'h43F0_0FFF);

    ctrlWrite("R6", 32'hC010_0002);
    ctrlWrite("R7", 32'h8010_0002);
    rd(12'hA0, v); check("R7", v, 32'hCAFE_F00D);
    ctrlWrite("R7", 32'h8010_0003);

    wr(12'hA4, 32'h1234_5678); mOut = 32'h1234_5678;
    ctrlWrite("R8", 32'hC020_0001);
    ctrlWrite("R8", 32'h8000_0000);
    ctrlWrite("R9", 32'hC010_0004);
    ctrlWrite("R9", 32'h8010_0FFF);
    ctrlWrite("R5", 32'hC010_0000);

    wr(12'hA0, 32'hFFFF_FFFF);
    wr(12'hAC, 32'hFFFF_FFFF);
    checkRegs("R10");

    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'hA9, 32'hFFFF_FFFF);
    rd(12'h010, v); check("R11", v, 32'h0);
    rd(12'hFFC, v); check("R11", v, 32'h0);
    checkRegs("R11");
    checkOsc("R11");

    for (int n = 0; n < 60; n++) begin
      logic [31:0] d;
      logic [11:0] dev;
      logic [5:0]  fn;
      dev = 12'($urandom_range(0, DEPTH + 1));
      fn  = ($urandom_range(0, 3) == 0) ? 6'($urandom_range(0, 63)) : 6'd1;
      d   = $urandom();
      wr(12'hA4, d); mOut = d;
      d = {1'b1, 1'($urandom_range(0, 1)), 4'($urandom), fn, 8'($urandom), dev};
      if ($urandom_range(0, 7) == 0) d[31] = 1'b0;
      ctrlWrite(d[31] ? (isValid(keepCtrl(d)) ? (d[30] ? "R6" : "R7") :
                         ((fn != 6'd1) ? "R8" : "R9")) : "R12", d);
      rd(12'hA8, v); check("R3", v, mCtrl);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule